// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Controller

This block watches a pair of 32-entry FIFOs, one carrying transmit data and one carrying receive data, and turns their fill levels and access errors into one level-sensitive interrupt. It does not store FIFO data. The FIFO logic supplies the current occupancy of each FIFO and strobes for the events that can misuse them. These are a bus-side push into the transmit FIFO, a serial-side push into the receive FIFO and a bus-side pop from the receive FIFO.

Five interrupt sources exist. Two are threshold comparisons. Receive-ready is high while the receive occupancy is greater than its threshold. Transmit-low is high while the transmit occupancy is at or below its threshold. These two follow the levels and drop by themselves when the condition ends. The other three latch and stay set until software clears them: transmit overflow, receive overflow and receive underflow.

Software uses a small word-addressed register window. It can program the two thresholds and a source mask, read both occupancies, read the raw and masked source vectors, and clear the latched sources. Clearing works either one source at a time or all at once. Register access is a plain strobe with a combinational read path. No data stream crosses the block edge, so it has no valid/ready handshake and applies no back-pressure.

Top module: `fic_irq_ctrl`

## Requirements
- R1: After reset both thresholds read 0, the mask reads 0, all latched sources are 0 and `irq` is low.
- R2: The register window is decoded from `reg_addr`:
  - Address 0 is the transmit threshold and address 1 is the receive threshold. Each is read/write and 5 bits wide.
  - Address 2 is the transmit occupancy and address 3 is the receive occupancy. Each is read-only, 6 bits wide and reads 0 to 32.
  - Address 4 is the raw source vector (read-only) and address 5 is the mask (read/write, 5 bits).
  - Address 6 is the masked vector (read-only) and address 7 is the clear register (write-only, reads 0).
  - Write data bits above a field's width are dropped, and all unused read bits are 0.
- R3: Source bit 4 (receive-ready) is 1 exactly while `rx_level` is greater than the receive threshold. It follows the level in the same cycle and is not latched.
- R4: Source bit 0 (transmit-low) is 1 exactly while `tx_level` is less than or equal to the transmit threshold. It follows the level in the same cycle and is not latched.
- R5: A `tx_push` while `tx_level` is 32 sets source bit 1 (transmit overflow). An `rx_push` while `rx_level` is 32 sets source bit 3 (receive overflow). A push at any lower level sets nothing. Both bits stay set after the strobe ends.
- R6: An `rx_pop` while `rx_level` is 0 sets source bit 2 (receive underflow). That bit stays set until cleared, and a pop at a nonzero level sets nothing.
- R7: In a write to the clear register, bit 3 clears transmit overflow, bit 2 clears receive overflow and bit 1 clears receive underflow. Each clear affects only its own source. Latched sources change on the clock edge after the event or the write.
- R8: Clear-register bit 0 clears all three latched sources in one write.
- R9: If a set event and a clear for the same latched source fall in the same cycle, the source ends up set.
- R10: The masked vector equals the raw vector AND the mask, with the same bit positions in raw, mask and masked.
- R11: `irq` is the OR of the masked vector. With a mask of 0 it is low whatever the sources are.
- R12: Writes to the read-only addresses (2, 3, 4, 6) change no register and no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle it is high |
| reg_addr | input | 3 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| tx_level | input | 6 | Current transmit FIFO occupancy, 0 to 32 |
| rx_level | input | 6 | Current receive FIFO occupancy, 0 to 32 |
| tx_push | input | 1 | Bus-side write into the transmit FIFO |
| rx_push | input | 1 | Serial-side write into the receive FIFO |
| rx_pop | input | 1 | Bus-side read from the receive FIFO |
| irq | output | 1 | Level interrupt, OR of the masked sources |

## Verification
The assertions take for granted that both occupancy inputs stay within 0 to 32. They also assume each strobe describes an access attempted at the level presented in that same cycle, so error detection can be judged from that cycle alone. The stimulus respects both assumptions:
- Every level and strobe is set on the falling clock edge and held across the next rising edge.
- Levels are only ever driven with values between 0 and 32, including the 0 and 32 end points where the error events live.

The latched-source properties assume that a clear-register write and an event for the same source can coincide. The bench deliberately produces that case to exercise the set-over-clear rule.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int SRC_TX_LOW   = 0;
  localparam int SRC_TX_OVF   = 1;
  localparam int SRC_RX_UDF   = 2;
  localparam int SRC_RX_OVF   = 3;
  localparam int SRC_RX_READY = 4;
  localparam int NUM_SRC      = 5;

  localparam int CLR_ALL    = 0;
  localparam int CLR_RX_UDF = 1;
  localparam int CLR_RX_OVF = 2;
  localparam int CLR_TX_OVF = 3;
  localparam int NUM_CLR    = 4;

  localparam int NUM_STICKY = 3;
  localparam int STK_RX_UDF = 0;
  localparam int STK_RX_OVF = 1;
  localparam int STK_TX_OVF = 2;

  typedef enum logic [2:0] {
    A_TX_THR  = 3'd0,
    A_RX_THR  = 3'd1,
    A_TX_LVL  = 3'd2,
    A_RX_LVL  = 3'd3,
    A_RAW     = 3'd4,
    A_MASK    = 3'd5,
    A_MASKED  = 3'd6,
    A_CLEAR   = 3'd7
  } fic_addr_e;
endpackage

// File: rtl/fic_thresh_cmp.sv
module fic_thresh_cmp #(
  parameter int LVL_W = 6,
  parameter int THR_W = 5,
  parameter bit ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  logic [LVL_W-1:0] thr_ext;
  assign thr_ext = LVL_W'(thr);

  generate
    if (ABOVE) begin : g_above
      assign hit = (level > thr_ext);
      // An empty FIFO never satisfies a "more than" comparison
      p_rx_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !hit);
    end else begin : g_at_or_below
      assign hit = (level <= thr_ext);
      // A drained FIFO always satisfies an "at or below" comparison
      p_tx_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> hit);
    end
  endgenerate
endmodule

// File: rtl/fic_sticky.sv
module fic_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag[i] <= 1'b0;
        else if (set_ev[i]) flag[i] <= 1'b1;
        else if (clr[i])    flag[i] <= 1'b0;
      end

      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !clr[i]) |=> flag[i]);
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set_ev[i]) |=> !flag[i]);
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[i] |=> flag[i]);
    end
  endgenerate
endmodule

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int THR_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] masked,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_CLR-1:0] clr_req,
  output logic [DATA_W-1:0] reg_rdata
);
  fic_addr_e addr;
  assign addr = fic_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
      mask   <= '0;
    end else if (reg_wr) begin
      case (addr)
        A_TX_THR: tx_thr <= reg_wdata[THR_W-1:0];
        A_RX_THR: rx_thr <= reg_wdata[THR_W-1:0];
        A_MASK:   mask   <= reg_wdata[NUM_SRC-1:0];
        default:  ;
      endcase
    end
  end

  assign clr_req = (reg_wr && addr == A_CLEAR) ? reg_wdata[NUM_CLR-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (addr)
      A_TX_THR: reg_rdata = DATA_W'(tx_thr);
      A_RX_THR: reg_rdata = DATA_W'(rx_thr);
      A_TX_LVL: reg_rdata = DATA_W'(tx_level);
      A_RX_LVL: reg_rdata = DATA_W'(rx_level);
      A_RAW:    reg_rdata = DATA_W'(raw);
      A_MASK:   reg_rdata = DATA_W'(mask);
      A_MASKED: reg_rdata = DATA_W'(masked);
      default:  reg_rdata = '0;
    endcase
  end

  p_thr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (addr == A_TX_THR || addr == A_RX_THR)) |=> ($stable(tx_thr) && $stable(rx_thr)));
  p_mask_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && addr == A_MASK) |=> $stable(mask));
endmodule

// File: rtl/fic_irq_ctrl.sv
module fic_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int THR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_push,
  input  logic              rx_pop,
  output logic              irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [THR_W-1:0]      tx_thr, rx_thr;
  logic [NUM_SRC-1:0]    mask, raw, masked;
  logic [NUM_CLR-1:0]    clr_req;
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_flag;
  logic                  rx_ready, tx_low;

  fic_cfg_regs #(.LVL_W(LVL_W), .THR_W(THR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level),
    .raw(raw), .masked(masked), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .mask(mask), .clr_req(clr_req), .reg_rdata(reg_rdata)
  );

  fic_thresh_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rx_cmp (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rx_thr), .hit(rx_ready)
  );

  fic_thresh_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_tx_cmp (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(tx_thr), .hit(tx_low)
  );

  always_comb begin
    stk_set[STK_RX_UDF] = rx_pop  && (rx_level == '0);
    stk_set[STK_RX_OVF] = rx_push && (rx_level == FULL_LVL);
    stk_set[STK_TX_OVF] = tx_push && (tx_level == FULL_LVL);
    stk_clr[STK_RX_UDF] = clr_req[CLR_ALL] | clr_req[CLR_RX_UDF];
    stk_clr[STK_RX_OVF] = clr_req[CLR_ALL] | clr_req[CLR_RX_OVF];
    stk_clr[STK_TX_OVF] = clr_req[CLR_ALL] | clr_req[CLR_TX_OVF];
  end

  fic_sticky #(.N(NUM_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_ev(stk_set), .clr(stk_clr), .flag(stk_flag)
  );

  always_comb begin
    raw                = '0;
    raw[SRC_TX_LOW]    = tx_low;
    raw[SRC_TX_OVF]    = stk_flag[STK_TX_OVF];
    raw[SRC_RX_UDF]    = stk_flag[STK_RX_UDF];
    raw[SRC_RX_OVF]    = stk_flag[STK_RX_OVF];
    raw[SRC_RX_READY]  = rx_ready;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL_LVL) && (rx_level <= FULL_LVL));
  p_tx_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_level == FULL_LVL) |=> raw[SRC_TX_OVF]);
  p_rx_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == FULL_LVL) |=> raw[SRC_RX_OVF]);
  p_rx_udf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0) |=> raw[SRC_RX_UDF]);
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req[CLR_ALL] && stk_set == '0) |=> (raw[SRC_TX_OVF:SRC_TX_OVF] == 1'b0 &&
                                            raw[SRC_RX_OVF:SRC_RX_UDF] == 2'b00));
  p_mask_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) |-> !irq);
endmodule

// File: tb/tb_fic_irq_ctrl.sv
module tb_fic_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  tx_level = 6'd0;
  logic [5:0]  rx_level = 6'd0;
  logic        tx_push = 1'b0;
  logic        rx_push = 1'b0;
  logic        rx_pop = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fic_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .tx_push(tx_push), .rx_push(rx_push),
    .rx_pop(rx_pop), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Pulse strobes for one clock at given levels
  task automatic pulse(input logic tp, input logic rp, input logic ro);
    tx_push = tp; rx_push = rp; rx_pop = ro;
    step();
    tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 tx threshold", d, 0);
    rd(3'd1, d); chk("R1 rx threshold", d, 0);
    rd(3'd5, d); chk("R1 mask", d, 0);
    rd(3'd4, d); chk("R1 raw (only tx-low at level 0)", d, 32'h01);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FF3F); rd(3'd0, d); chk("R2 tx threshold width", d, 32'h1F);
    wr(3'd1, 32'h0000_0025); rd(3'd1, d); chk("R2 rx threshold width", d, 32'h05);
    wr(3'd5, 32'h0000_00FF); rd(3'd5, d); chk("R2 mask width", d, 32'h1F);
    tx_level = 6'd17; rx_level = 6'd32;
    rd(3'd2, d); chk("R2 tx level", d, 17);
    rd(3'd3, d); chk("R2 rx level 32", d, 32);
    rd(3'd7, d); chk("R2 clear reads 0", d, 0);
    wr(3'd5, 0); wr(3'd0, 0); wr(3'd1, 0);
    tx_level = 6'd0; rx_level = 6'd0;
  endtask

  task automatic t_rx_ready();
    logic [31:0] d;
    wr(3'd1, 3);
    rx_level = 6'd3; rd(3'd4, d); chk("R3 rx level equal thr", d[4], 0);
    rx_level = 6'd4; rd(3'd4, d); chk("R3 rx level above thr", d[4], 1);
    rx_level = 6'd2; rd(3'd4, d); chk("R3 self-clears", d[4], 0);
    wr(3'd1, 31); rx_level = 6'd32; rd(3'd4, d); chk("R3 thr 31 at 32", d[4], 1);
    rx_level = 6'd0; wr(3'd1, 0);
  endtask

  task automatic t_tx_low();
    logic [31:0] d;
    wr(3'd0, 16);
    tx_level = 6'd17; rd(3'd4, d); chk("R4 tx above thr", d[0], 0);
    tx_level = 6'd16; rd(3'd4, d); chk("R4 tx at thr", d[0], 1);
    wr(3'd0, 0);
    tx_level = 6'd1; rd(3'd4, d); chk("R4 thr 0 level 1", d[0], 0);
    tx_level = 6'd0; rd(3'd4, d); chk("R4 thr 0 drained", d[0], 1);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    tx_level = 6'd31; rx_level = 6'd31;
    pulse(1, 1, 0); rd(3'd4, d); chk("R5 push below full", d & 32'h0A, 0);
    tx_level = 6'd32;
    pulse(1, 0, 0); rd(3'd4, d); chk("R5 tx overflow", d & 32'h0A, 32'h02);
    rx_level = 6'd32;
    pulse(0, 1, 0); rd(3'd4, d); chk("R5 rx overflow", d & 32'h0A, 32'h0A);
    tx_level = 6'd5; rx_level = 6'd5; step();
    rd(3'd4, d); chk("R5 overflow sticky", d & 32'h0A, 32'h0A);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    rx_level = 6'd1;
    pulse(0, 0, 1); rd(3'd4, d); chk("R6 pop nonempty", d[2], 0);
    rx_level = 6'd0;
    pulse(0, 0, 1); step(); rd(3'd4, d); chk("R6 underflow sticky", d[2], 1);
  endtask

  task automatic t_clear_each();
    logic [31:0] d;
    wr(3'd7, 32'h8); rd(3'd4, d); chk("R7 clear tx overflow", d & 32'h0E, 32'h0C);
    wr(3'd7, 32'h4); rd(3'd4, d); chk("R7 clear rx overflow", d & 32'h0E, 32'h04);
    wr(3'd7, 32'h2); rd(3'd4, d); chk("R7 clear rx underflow", d & 32'h0E, 32'h00);
  endtask

  task automatic t_clear_all();
    logic [31:0] d;
    tx_level = 6'd32; rx_level = 6'd32; pulse(1, 1, 0);
    rx_level = 6'd0; pulse(0, 0, 1);
    rd(3'd4, d); chk("R8 all latched set", d & 32'h0E, 32'h0E);
    tx_level = 6'd0;
    wr(3'd7, 32'h1); rd(3'd4, d); chk("R8 clear all", d & 32'h0E, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    rx_level = 6'd32; pulse(0, 1, 0);
    rx_level = 6'd0;
    rx_pop = 1'b1;
    wr(3'd7, 32'h1);
    rx_pop = 1'b0;
    rd(3'd4, d); chk("R9 set beats clear", d & 32'h0E, 32'h04);
    wr(3'd7, 32'h1);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    rx_level = 6'd32; pulse(0, 1, 0);
    chk("R11 mask zero keeps irq low", {31'd0, irq}, 0);
    wr(3'd5, 32'h08);
    rd(3'd6, d); chk("R10 masked vector", d, 32'h08);
    chk("R11 irq on masked source", {31'd0, irq}, 1);
    wr(3'd5, 32'h10); wr(3'd1, 31); rx_level = 6'd0;
    rd(3'd6, d); chk("R10 masked excludes unmasked", d, 0);
    chk("R11 irq low", {31'd0, irq}, 0);
    wr(3'd5, 32'h1F);
    rd(3'd6, d); chk("R10 full mask", d, 32'h09);
    wr(3'd5, 0); wr(3'd1, 0); wr(3'd7, 32'h1);
  endtask

  task automatic t_ro_ignored();
    logic [31:0] d;
    wr(3'd0, 7); wr(3'd5, 32'h02);
    wr(3'd2, 32'h1F); wr(3'd3, 32'h1F); wr(3'd4, 32'h1F); wr(3'd6, 32'h1F);
    rd(3'd0, d); chk("R12 tx threshold untouched", d, 7);
    rd(3'd1, d); chk("R12 rx threshold untouched", d, 0);
    rd(3'd5, d); chk("R12 mask untouched", d, 32'h02);
    rd(3'd4, d); chk("R12 raw untouched", d & 32'h0E, 0);
    wr(3'd0, 0); wr(3'd5, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rx_ready();
    t_tx_low();
    t_overflow();
    t_underflow();
    t_clear_each();
    t_clear_all();
    t_set_wins();
    t_mask_irq();
    t_ro_ignored();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule